// File: doc/BRIEF.md
# Bidirectional I/O Direction Arbiter

The block joins a host-side open-drain line to a card-side open-drain line when neither side supplies a direction signal. It does this for several independent line pairs: a data line and two auxiliary lines by default. Each line is seen through a sampled input and a drive-low enable output. The line itself is the wired-AND of every agent that drives it.

While arbitration is enabled, both sides of every pair rest released and high. Whichever side of a pair shows a falling edge first becomes that pair's input. The block then pulls the opposite side low to copy it. When the input side rises again, the block releases the copy and the pair returns to neutral, ready for the next arbitration.

The card side of every pair is held low until the activation sequencer grants card reception. Both inputs pass through a two-stage synchroniser before any edge is detected.

Top module: `io_dir_arbiter`

## Requirements
- R1: While reset is asserted and afterwards until `rx_en` rises, every `host_drv_lo` bit is 0 (host side released) and every `card_drv_lo` bit is 1 (card side held low).
- R2: Whenever `rx_en` is 0, every `card_drv_lo` bit is 1 and every `host_drv_lo` bit is 0, whatever the line activity.
- R3: While `arb_en` is 0 and `rx_en` is 1, no drive output is asserted and falling edges on either side are ignored.
- R4: With `rx_en` and `arb_en` both 1 and a pair neutral, a host-side fall makes `card_drv_lo` of that pair 1 on the third rising clock edge after the input change; it is still 0 after the second edge.
- R5: With the pair neutral, a card-side fall makes `host_drv_lo` of that pair 1 on the third rising clock edge after the change.
- R6: A rise on the input side releases the copy drive on the third rising edge after the rise, and the pair can be arbitrated again afterwards.
- R7: If both sides of a pair fall in the same sampled cycle, the host side becomes the input (`card_drv_lo` = 1, `host_drv_lo` = 0).
- R8: While a direction is latched, edges on the output side, including the fall caused by the block's own drive, change nothing. A pair never switches from one direction straight to the other.
- R9: Clearing `arb_en` releases every copy drive in the same cycle, with no clock edge needed. A line that is still low when `arb_en` is set again is not re-latched, because no new edge has occurred.
- R10: Each pair is arbitrated independently; activity on one pair leaves the drive outputs of the other pairs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_en | input | 1 | Arbitration enable from the control register |
| rx_en | input | 1 | Card reception granted by the activation sequencer |
| host_in | input | NUM_PAIRS | Sampled level of each host-side line |
| card_in | input | NUM_PAIRS | Sampled level of each card-side line |
| host_drv_lo | output | NUM_PAIRS | 1 pulls the host-side line low |
| card_drv_lo | output | NUM_PAIRS | 1 pulls the card-side line low |

## Verification
A line edge reaches a drive output after three rising clock edges: two synchroniser stages and then the direction register. Changes to `arb_en` and `rx_en` act on the outputs combinationally.

The bench changes lines only at falling clock edges. For each edge-driven result it checks the output 1 ns after the second rising edge, where the old value must still hold, and 1 ns after the third, where the new value must be present. Enable changes are checked 1 ns after the input moves, before any clock edge. The "ignored" cases are held for several cycles and checked at the drive outputs.

// File: rtl/io_dir_arbiter.sv
module io_dir_arbiter #(
  parameter int NUM_PAIRS   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arb_en,
  input  logic                 rx_en,
  input  logic [NUM_PAIRS-1:0] host_in,
  input  logic [NUM_PAIRS-1:0] card_in,
  output logic [NUM_PAIRS-1:0] host_drv_lo,
  output logic [NUM_PAIRS-1:0] card_drv_lo
);

  typedef enum logic [1:0] {NEUTRAL, HOST_LEADS, CARD_LEADS} dir_t;

  logic active;
  assign active = arb_en & rx_en;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    logic [SYNC_STAGES:0] hs, cs;
    logic host_fall, host_rise, card_fall, card_rise;
    dir_t dir;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hs <= '1;
        cs <= '0;
      end else begin
        hs <= {hs[SYNC_STAGES-1:0], host_in[i]};
        cs <= {cs[SYNC_STAGES-1:0], card_in[i]};
      end
    end

    assign host_fall =  hs[SYNC_STAGES] & ~hs[SYNC_STAGES-1];
    assign host_rise = ~hs[SYNC_STAGES] &  hs[SYNC_STAGES-1];
    assign card_fall =  cs[SYNC_STAGES] & ~cs[SYNC_STAGES-1];
    assign card_rise = ~cs[SYNC_STAGES] &  cs[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dir <= NEUTRAL;
      else if (!active) dir <= NEUTRAL;
      else begin
        case (dir)
          NEUTRAL:    if (host_fall) dir <= HOST_LEADS;
                      else if (card_fall) dir <= CARD_LEADS;
          HOST_LEADS: if (host_rise) dir <= NEUTRAL;
          CARD_LEADS: if (card_rise) dir <= NEUTRAL;
          default:    dir <= NEUTRAL;
        endcase
      end
    end

    assign card_drv_lo[i] = ~rx_en | (active & (dir == HOST_LEADS));
    assign host_drv_lo[i] = active & (dir == CARD_LEADS);
  end

endmodule

// File: rtl/io_dir_arbiter_chk.sv
module io_dir_arbiter_chk #(
  parameter int NUM_PAIRS = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 arb_en,
  input logic                 rx_en,
  input logic [NUM_PAIRS-1:0] host_drv_lo,
  input logic [NUM_PAIRS-1:0] card_drv_lo
);

  assert_rx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> (card_drv_lo == '1 && host_drv_lo == '0));

  assert_disabled_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!arb_en && rx_en) |-> (card_drv_lo == '0 && host_drv_lo == '0));

  assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |-> ((host_drv_lo & card_drv_lo) == '0));

  assert_no_direct_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_en && rx_en && $past(arb_en && rx_en)) |->
      ((host_drv_lo & $past(card_drv_lo)) == '0 && (card_drv_lo & $past(host_drv_lo)) == '0));

endmodule

bind io_dir_arbiter io_dir_arbiter_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .rx_en(rx_en),
  .host_drv_lo(host_drv_lo), .card_drv_lo(card_drv_lo)
);

// File: tb/tb_io_dir_arbiter.sv
module tb_io_dir_arbiter;
  localparam int N = 3;

  logic clk = 0, rst_n = 0, arb_en = 0, rx_en = 0;
  logic [N-1:0] host_ext = '1, card_ext = '1;
  logic [N-1:0] host_in, card_in, host_drv_lo, card_drv_lo;
  int total = 0, failed = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign host_in = host_ext & ~host_drv_lo;
  assign card_in = card_ext & ~card_drv_lo;

  io_dir_arbiter #(.NUM_PAIRS(N)) dut (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .rx_en(rx_en),
    .host_in(host_in), .card_in(card_in),
    .host_drv_lo(host_drv_lo), .card_drv_lo(card_drv_lo)
  );

  task automatic chk(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: {host_drv_lo,card_drv_lo} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic expect_drv(input string req, input logic [N-1:0] h, input logic [N-1:0] c);
    chk(req, {host_drv_lo, card_drv_lo}, {h, c});
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic to_negedge();
    @(negedge clk);
  endtask

  task automatic t_reset();
    edges(1);
    expect_drv("R1 in reset", '0, '1);
    to_negedge(); rst_n = 1;
    edges(4);
    expect_drv("R1 after reset", '0, '1);
  endtask

  task automatic t_rx_gate();
    to_negedge(); arb_en = 1; host_ext[0] = 0;
    edges(5);
    expect_drv("R2 rx_en low ignores fall", '0, '1);
    to_negedge(); host_ext[0] = 1; arb_en = 0;
    edges(4);
    to_negedge(); rx_en = 1;
    #1 expect_drv("R2 rx_en releases card side", '0, '0);
    edges(4);
  endtask

  task automatic t_disabled();
    to_negedge(); host_ext[1] = 0;
    edges(5);
    expect_drv("R3 host fall while disabled", '0, '0);
    to_negedge(); arb_en = 1;
    edges(5);
    expect_drv("R3 no latch on enable without edge", '0, '0);
    to_negedge(); host_ext[1] = 1; card_ext[2] = 0; arb_en = 0;
    edges(5);
    expect_drv("R3 card fall while disabled", '0, '0);
    to_negedge(); card_ext[2] = 1; arb_en = 1;
    edges(5);
  endtask

  task automatic t_host_leads();
    to_negedge(); host_ext[0] = 0;
    edges(2);
    expect_drv("R4 not yet after two edges", '0, '0);
    edges(1);
    expect_drv("R4 card copy after three edges", '0, 3'b001);
    edges(6);
    expect_drv("R8 own drive fall ignored", '0, 3'b001);
    to_negedge(); card_ext[0] = 0;
    edges(3);
    to_negedge(); card_ext[0] = 1;
    edges(4);
    expect_drv("R8 output side pulse ignored", '0, 3'b001);
    to_negedge(); host_ext[0] = 1;
    edges(2);
    expect_drv("R6 held until third edge", '0, 3'b001);
    edges(1);
    expect_drv("R6 released after rise", '0, '0);
    edges(6);
    expect_drv("R8 no lock-up after release", '0, '0);
  endtask

  task automatic t_card_leads();
    to_negedge(); card_ext[1] = 0;
    edges(2);
    expect_drv("R5 not yet after two edges", '0, '0);
    edges(1);
    expect_drv("R5 host copy after three edges", 3'b010, '0);
    expect_drv("R10 other pairs untouched", 3'b010, '0);
    to_negedge(); card_ext[1] = 1;
    edges(3);
    expect_drv("R6 card side release", '0, '0);
    edges(4);
    to_negedge(); host_ext[1] = 0;
    edges(3);
    expect_drv("R6 rearbitration reverses direction", '0, 3'b010);
    to_negedge(); host_ext[1] = 1;
    edges(6);
  endtask

  task automatic t_tie();
    to_negedge(); host_ext[2] = 0; card_ext[2] = 0;
    edges(3);
    expect_drv("R7 host wins simultaneous fall", '0, 3'b100);
    to_negedge(); host_ext[2] = 1;
    edges(3);
    expect_drv("R7 release after host rise", '0, '0);
    to_negedge(); card_ext[2] = 1;
    edges(6);
    expect_drv("R7 quiet after card rise", '0, '0);
  endtask

  task automatic t_disable_release();
    to_negedge(); host_ext[0] = 0; card_ext[2] = 0;
    edges(3);
    expect_drv("R10 two pairs latched", 3'b100, 3'b001);
    to_negedge(); arb_en = 0;
    #1 expect_drv("R9 immediate release", '0, '0);
    edges(3);
    to_negedge(); arb_en = 1;
    edges(6);
    expect_drv("R9 no relatch without edge", '0, '0);
    to_negedge(); host_ext[0] = 1; card_ext[2] = 1;
    edges(6);
    to_negedge(); card_ext[0] = 0;
    edges(3);
    expect_drv("R2 setup card lead", 3'b001, '0);
    to_negedge(); rx_en = 0;
    #1 expect_drv("R2 rx_en drop holds card side", '0, '1);
    to_negedge(); card_ext[0] = 1;
    edges(4);
  endtask

  initial begin
    t_reset();
    t_rx_gate();
    t_disabled();
    t_host_leads();
    t_card_leads();
    t_tie();
    t_disable_release();
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule